// File: doc/BRIEF.md
# Clock-Generator Configuration Slave on SMBus

This block is the serial configuration endpoint of a clock-distribution device. It watches the two wires of an SMBus segment and answers at a 7-bit address. The upper five bits of that address are fixed at `11011`. The lower two bits come from strap pins, so up to four devices can share one bus: write addresses 0xD8, 0xDA, 0xDC and 0xDE, and the matching read addresses one higher. Behind the address sits a three-byte register file. Byte 0 holds the PLL multiplier code and the per-output enables, byte 1 holds spare bits, and byte 2 is a read-only identity byte.

Both directions use an indexed block protocol. To write, the host sends the write address, a starting index, a byte count and then the data bytes, which land at consecutive indices. To read, the host sets the index with a write-address frame, issues a repeated start and sends the read address. The slave then returns a byte count followed by data from the starting index onward, until the host answers with a NACK.

The register contents drive the core directly. A 3-bit multiplier code goes to the PLL. Four clock-enable lines are each qualified by a global output-enable pin. A mode pin passes straight through as the PLL/bypass select.

Top module: `smbus_clkcfg_slave`

## Requirements
- R1: The slave acknowledges only the address `{11011, addr_strap[1], addr_strap[0]}` (bit 0 is R/W, 0 = write). Any other address gets no ACK, and the slave drives nothing until the next start.
- R2: In a block write, the slave acks the index N, the count X and every data byte, and stores the X data bytes at indices N through N+X-1.
- R3: Data bytes beyond the count, and bytes aimed at indices above 2, are acked and change no state. Reads of indices above 2 return 0x00.
- R4: Byte 2 reads as `{REV_ID[4:0], 3'b001}`, and writes to it have no effect.
- R5: In a read after the read address, the slave first sends the count 3 and then sends bytes from the current index upward, advancing the index after each byte.
- R6: A host NACK on any read byte ends the transfer, and the slave releases SDA.
- R7: After reset, byte 0 is 0x1F (multiplier code 001, all four enables set) and byte 1 is 0x00.
- R8: `mult_sel` equals bits 6:4 of byte 0.
- R9: `clk_en[i]` is high only when `oe_pin` is high and bit (3-i) of byte 0 is set. Bit 3 maps to output 0 and bit 0 maps to output 3.
- R10: `pll_mode` follows `pll_sel_pin` (1 = PLL, 0 = bypass).
- R11: A stop at any point aborts the transfer without a partial write. A start at any point returns the slave to the address phase, and the index is kept.
- R12: The slave pulls SDA low only to ACK or to send a 0 bit, and it changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SMBus clock line as seen at the pad |
| sda_i | input | 1 | SMBus data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (open-drain drive) |
| addr_strap | input | 2 | Low two bits of the slave address |
| oe_pin | input | 1 | Global output enable, high = outputs may run |
| pll_sel_pin | input | 1 | Mode select, 1 = PLL, 0 = bypass |
| mult_sel | output | 3 | PLL multiplier code |
| clk_en | output | 4 | Per-output enable, low = tri-state |
| pll_mode | output | 1 | Mode select passed to the core |

## Verification
The assertions assume that SCL and SDA are much slower than `clk`. Each SCL level must last longer than the synchronizer plus edge-detect delay of three cycles. The host must also move SDA only while SCL is low, except to form a start or a stop. The bench host holds every SCL phase for eight system clocks and changes its data only in the middle of the low phase, so every edge the slave detects is in the order the wires saw it. Aborts are only made as legal start and stop conditions, never as glitches.

// File: rtl/smbus_clkcfg_slave.sv
module smbus_clkcfg_slave #(
  parameter logic [4:0] ADDR_PREFIX = 5'b11011,
  parameter logic [4:0] REV_ID      = 5'h03,
  parameter logic [7:0] RD_COUNT    = 8'd3,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_strap,
  input  logic       oe_pin,
  input  logic       pll_sel_pin,
  output logic [2:0] mult_sel,
  output logic [3:0] clk_en,
  output logic       pll_mode
);

  localparam logic [7:0] ID_BYTE   = {REV_ID, 3'b001};
  localparam logic [7:0] BYTE0_RST = 8'h1F;
  localparam int         NOUT      = 4;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} st_t;
  typedef enum logic [1:0] {K_ADDR, K_INDEX, K_COUNT, K_DATA} kind_t;

  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  st_t   st;
  kind_t kind;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, idx, remain, reg0, reg1, rd_data, next_idx;
  logic       rd_mode, host_ack, byte_done, addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_p  <= scl_s;
      sda_p  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_STAGES-1];
  assign sda_s     = sda_ff[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  assign byte_done = (st == S_RX) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == {ADDR_PREFIX, addr_strap});
  assign next_idx  = (idx == 8'hFF) ? idx : idx + 8'd1;

  always_comb begin
    case (idx)
      8'd0:    rd_data = reg0;
      8'd1:    rd_data = reg1;
      8'd2:    rd_data = ID_BYTE;
      default: rd_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '1;
      idx      <= '0;
      remain   <= '0;
      rd_mode  <= 1'b0;
      host_ack <= 1'b0;
      reg0     <= BYTE0_RST;
      reg1     <= '0;
    end else if (start_det) begin
      st     <= S_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
    end else if (stop_det) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            st <= S_RXACK;
            case (kind)
              K_ADDR: begin
                if (addr_hit) begin
                  rd_mode <= shreg[0];
                  kind    <= K_INDEX;
                end else begin
                  st <= S_IDLE;
                end
              end
              K_INDEX: begin
                idx  <= shreg;
                kind <= K_COUNT;
              end
              K_COUNT: begin
                remain <= shreg;
                kind   <= K_DATA;
              end
              default: begin
                if (remain != 8'd0) begin
                  remain <= remain - 8'd1;
                  idx    <= next_idx;
                  if (idx == 8'd0) reg0 <= shreg;
                  if (idx == 8'd1) reg1 <= shreg;
                end
              end
            endcase
          end
        end
        S_RXACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rd_mode && kind == K_INDEX) begin
              st   <= S_TX;
              txsh <= RD_COUNT;
            end else begin
              st <= S_RX;
            end
          end
        end
        S_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) st <= S_TXACK;
            else                txsh <= {txsh[6:0], 1'b1};
          end
        end
        S_TXACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_s;
          end else if (scl_fall) begin
            if (host_ack) begin
              st     <= S_TX;
              bitcnt <= '0;
              txsh   <= rd_data;
              idx    <= next_idx;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = (st == S_RXACK) || (st == S_TX && !txsh[7]);

  assign mult_sel = reg0[6:4];
  assign pll_mode = pll_sel_pin;

  for (genvar g = 0; g < NOUT; g++) begin : g_en
    assign clk_en[g] = oe_pin & reg0[NOUT-1-g];
  end

  p_addr_nack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_ADDR && !addr_hit) |=> (st == S_IDLE && !sda_oe));

  p_discard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == K_DATA && (idx > 8'd1 || remain == 8'd0))
      |=> ($stable(reg0) && $stable(reg1)));

  p_nack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TXACK && scl_fall && !host_ack) |=> !sda_oe);

  p_mult_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mult_sel) |-> $past(byte_done));

  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == S_IDLE));

  p_start_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_RX && kind == K_ADDR && bitcnt == 4'd0));

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

endmodule

// File: tb/smbus_clkcfg_slave_tb.sv
module smbus_clkcfg_slave_tb;
  localparam int P = 8;
  localparam logic [7:0] WR_A = 8'hDA;
  localparam logic [7:0] RD_A = 8'hDB;
  localparam logic [7:0] ID_B = 8'h19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic oe_pin = 1'b1, pll_sel_pin = 1'b1;
  logic [1:0] addr_strap = 2'b01;
  logic sda_oe, pll_mode;
  logic [2:0] mult_sel;
  logic [3:0] clk_en;
  wire sda_bus = host_sda & ~sda_oe;

  int checks = 0, errs = 0;
  bit cmp_en = 1'b1, done = 1'b0;
  logic [7:0] mdl [0:2];
  logic prev_oe = 1'b0;

  always #2 clk = ~clk;

  smbus_clkcfg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_strap(addr_strap), .oe_pin(oe_pin), .pll_sel_pin(pll_sel_pin),
    .mult_sel(mult_sel), .clk_en(clk_en), .pll_mode(pll_mode));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_en(input logic [7:0] b, input logic oe);
    logic [3:0] e;
    for (int i = 0; i < 4; i++) e[i] = oe & b[3-i];
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(mult_sel == mdl[0][6:4], "R8 mult_sel", mult_sel, mdl[0][6:4]);
      chk(clk_en == exp_en(mdl[0], oe_pin), "R9 clk_en", clk_en, exp_en(mdl[0], oe_pin));
      chk(pll_mode == pll_sel_pin, "R10 pll_mode", pll_mode, pll_sel_pin);
    end
    if (rst_n && sda_oe !== prev_oe) chk(host_scl == 1'b0, "R12 drive change with SCL high", host_scl, 0);
    prev_oe <= sda_oe;
  end

  task automatic waitp(); repeat (P) @(negedge clk); endtask

  task automatic clk_bit(input logic b, output logic s);
    host_sda = b; waitp();
    host_scl = 1'b1; waitp();
    s = sda_bus;
    host_scl = 1'b0; waitp();
  endtask

  task automatic bus_start();
    host_sda = 1'b1; waitp();
    host_scl = 1'b1; waitp();
    host_sda = 1'b0; waitp();
    host_scl = 1'b0; waitp();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; waitp();
    host_scl = 1'b1; waitp();
    host_sda = 1'b1; waitp();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(~give_ack, s);
  endtask

  task automatic set_index(input logic [7:0] n);
    logic a;
    bus_start();
    wbyte(WR_A, a); chk(a, "R1 write address ack", a, 1);
    wbyte(n, a);    chk(a, "R2 index ack", a, 1);
  endtask

  task automatic finish_sim();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errs++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_sim();
  end

  initial begin
    logic a;
    logic [7:0] d;
    mdl[0] = 8'h1F; mdl[1] = 8'h00; mdl[2] = ID_B;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    chk(mult_sel == 3'b001, "R7 reset mult_sel", mult_sel, 1);
    chk(clk_en == 4'hF, "R7 reset clk_en", clk_en, 4'hF);
    chk(sda_oe == 1'b0, "R7 reset sda idle", sda_oe, 0);

    set_index(8'd0);
    bus_start();
    wbyte(RD_A, a); chk(a, "R5 read address ack", a, 1);
    rbyte(1'b1, d); chk(d == 8'd3, "R5 count byte", d, 3);
    rbyte(1'b1, d); chk(d == 8'h1F, "R7 byte0 reset", d, 8'h1F);
    rbyte(1'b1, d); chk(d == 8'h00, "R7 byte1 reset", d, 0);
    rbyte(1'b0, d); chk(d == ID_B, "R4 id byte", d, ID_B);
    bus_stop();

    bus_start();
    wbyte(8'hD8, a); chk(!a, "R1 foreign address nack", a, 0);
    wbyte(8'h00, a); chk(!a, "R1 no ack after foreign address", a, 0);
    wbyte(8'h01, a);
    wbyte(8'h00, a);
    bus_stop();
    chk(mult_sel == 3'b001, "R1 foreign write had no effect", mult_sel, 1);

    cmp_en = 1'b0;
    set_index(8'd0);
    wbyte(8'd2, a);  chk(a, "R2 count ack", a, 1);
    wbyte(8'h5A, a); chk(a, "R2 data0 ack", a, 1);
    wbyte(8'h81, a); chk(a, "R2 data1 ack", a, 1);
    bus_stop();
    mdl[0] = 8'h5A; mdl[1] = 8'h81;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    chk(mult_sel == 3'b101, "R8 mult after write", mult_sel, 5);
    chk(clk_en == 4'b0101, "R9 enable bit order", clk_en, 4'b0101);

    set_index(8'd2);
    wbyte(8'd3, a);
    wbyte(8'hFF, a); chk(a, "R4 write to id acked", a, 1);
    wbyte(8'hFF, a); chk(a, "R3 write past end acked", a, 1);
    wbyte(8'hFF, a);
    bus_stop();
    set_index(8'd0);
    bus_start();
    wbyte(RD_A, a);
    rbyte(1'b1, d); chk(d == 8'd3, "R5 count byte", d, 3);
    rbyte(1'b1, d); chk(d == 8'h5A, "R2 byte0 readback", d, 8'h5A);
    rbyte(1'b1, d); chk(d == 8'h81, "R2 byte1 readback", d, 8'h81);
    rbyte(1'b1, d); chk(d == ID_B, "R4 id unchanged", d, ID_B);
    rbyte(1'b0, d); chk(d == 8'h00, "R3 index 3 reads zero", d, 0);
    bus_stop();

    cmp_en = 1'b0;
    set_index(8'd0);
    wbyte(8'd1, a);
    wbyte(8'h3C, a);
    wbyte(8'h77, a); chk(a, "R3 byte beyond count acked", a, 1);
    bus_stop();
    mdl[0] = 8'h3C;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    chk(clk_en == 4'b0011, "R9 enables 0x3C", clk_en, 4'b0011);
    set_index(8'd1);
    bus_start();
    wbyte(RD_A, a);
    rbyte(1'b1, d);
    rbyte(1'b0, d); chk(d == 8'h81, "R3 byte beyond count discarded", d, 8'h81);
    repeat (P) @(negedge clk);
    chk(sda_oe == 1'b0, "R6 release after nack", sda_oe, 0);
    bus_stop();

    set_index(8'd0);
    bus_start();
    wbyte(RD_A, a);
    rbyte(1'b0, d); chk(d == 8'd3, "R6 count then early nack", d, 3);
    for (int k = 0; k < 3 * P; k++) begin
      @(negedge clk);
      if (sda_oe) begin chk(1'b0, "R6 drove after nack", 1, 0); break; end
    end
    chk(sda_oe == 1'b0, "R6 bus free", sda_oe, 0);
    bus_stop();

    oe_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(clk_en == 4'h0, "R9 oe low disables all", clk_en, 0);
    oe_pin = 1'b1;
    pll_sel_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk(pll_mode == 1'b0, "R10 bypass select", pll_mode, 0);
    pll_sel_pin = 1'b1;

    set_index(8'd0);
    wbyte(8'd1, a);
    for (int i = 0; i < 4; i++) clk_bit(1'b0, a);
    bus_stop();
    repeat (4) @(negedge clk);
    chk(mult_sel == 3'b011, "R11 stop mid byte no write", mult_sel, 3);

    cmp_en = 1'b0;
    set_index(8'd1);
    bus_start();
    wbyte(WR_A, a); chk(a, "R11 repeated start address ack", a, 1);
    wbyte(8'd0, a);
    wbyte(8'd1, a);
    wbyte(8'h9F, a);
    bus_stop();
    mdl[0] = 8'h9F;
    repeat (4) @(negedge clk);
    cmp_en = 1'b1;
    chk(clk_en == 4'hF, "R11 write after restart", clk_en, 4'hF);
    set_index(8'd0);
    bus_start();
    wbyte(RD_A, a);
    rbyte(1'b1, d);
    rbyte(1'b0, d); chk(d == 8'h9F, "R2 test bit stored", d, 8'h9F);
    bus_stop();

    repeat (10) @(negedge clk);
    finish_sim();
  end
endmodule